// File: doc/BRIEF.md
# Soft-Ramping Two-Channel Digital Volume

This block scales two signed 24-bit audio channels by a linear gain of `level/255`, where each channel's level is an 8-bit value and 0 means silence. The level actually applied to the samples never jumps. It walks toward its goal one code at a time, and each step waits a fixed number of frames that depends on the sample-rate speed class. Volume changes and muting therefore stay free of clicks. A configuration block elsewhere supplies the per-channel target levels, the soft-mute request and the speed class. A frame strobe marks each new sample pair.

Each channel runs a small direction state machine. Its states are `ST_SETTLED` (applied level equals the goal), `ST_RISING` and `ST_FALLING`. The transitions are:
- *depart-up* and *depart-down* leave `ST_SETTLED` when the goal moves away.
- *arrive* returns to `ST_SETTLED` when the level reaches the goal.
- *reverse* swaps `ST_RISING` and `ST_FALLING` when the goal crosses to the other side of the present level.

The goal is 0 while soft mute is held and the target level otherwise. One shared step timer counts frame strobes while either channel is away from its goal, and emits a step tick at the end of each period.

Top module: `vol_ramp_attenuator`

## Requirements
- R1: After reset both applied levels read 0xFF, both outputs read 0 and `out_valid` is low. The two channels' levels are independent of each other.
- R2: The applied level changes only on a step tick. At each tick it moves by exactly one code toward its goal, which is 0 while `soft_mute` is 1 and the channel's target level otherwise.
- R3: The step period is 4 frame strobes for `speed_mode` 00, 8 for 01, and 16 for 10 or 11. When a settled channel's goal changes, its first step comes on the period-th strobe after the change.
- R4: A full ramp from 255 to 0 takes 255 step periods: 1020, 2040 or 4080 strobes.
- R5: Asserting soft mute ramps the level down to 0. Releasing it ramps the level back up to the target, at the same rate in both directions.
- R6: If soft mute is released before the level reaches 0, the ramp reverses from the present level and climbs to the target.
- R7: If the target changes mid-ramp, the level heads from its present value toward the new target, up or down as needed.
- R8: On each strobe the outputs register `sample*level/255`, truncated toward zero, using the level applied at that strobe. `out_valid` is high for the one cycle after the strobe.
- R9: A pulse on `timing_clr` restarts the step count from zero and leaves the applied levels unchanged.
- R10: The step count advances only on a frame strobe, and only while some channel is off its goal. With both channels settled it is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timing_clr | input | 1 | Clears the step count, keeps the levels |
| frame_stb | input | 1 | One-cycle pulse per sample frame |
| speed_mode | input | 2 | 00 normal, 01 double, 10/11 quad |
| soft_mute | input | 1 | 1 ramps both channels to silence |
| target_l | input | 8 | Left target level |
| target_r | input | 8 | Right target level |
| sample_l | input | 24 | Left signed sample |
| sample_r | input | 24 | Right signed sample |
| out_l | output | 24 | Left scaled sample |
| out_r | output | 24 | Right scaled sample |
| out_valid | output | 1 | High the cycle after a strobe |
| level_l | output | 8 | Left applied level |
| level_r | output | 8 | Right applied level |

## Verification
The bench first times every step against the frame count in each speed class, so a design with the wrong period, or one that ticks on clock cycles instead of strobes, drifts at the first step. It releases soft mute halfway down a ramp and redirects a target mid-ramp; a design that finishes the old ramp first, or snaps to the target, leaves the predicted level trace. It feeds extreme and negative samples at odd levels, which exposes flooring instead of truncation toward zero and off-by-one level use. It also clears the step timer in mid-count, which catches a design that drops the levels as well or fails to restart the count.

// File: rtl/vr_pkg.sv
package vr_pkg;
    localparam int LVL_W  = 8;
    localparam int SMP_W  = 24;
    localparam int NCH    = 2;

    typedef enum logic [1:0] {
        ST_SETTLED = 2'd0,
        ST_RISING  = 2'd1,
        ST_FALLING = 2'd2
    } ramp_state_t;

    // frames per step for a speed class; class 3 is treated as quad
    function automatic int unsigned step_period(input logic [1:0] mode, input int unsigned base);
        unique case (mode)
            2'b00:   return base;
            2'b01:   return base * 2;
            default: return base * 4;
        endcase
    endfunction
endpackage

// File: rtl/vr_step_timer.sv
module vr_step_timer
    import vr_pkg::*;
#(
    parameter int unsigned BASE_PERIOD = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       stb,
    input  logic       busy,
    input  logic [1:0] mode,
    output logic       tick
);
    localparam int unsigned MAX_PER = BASE_PERIOD * 4;
    localparam int CW = $clog2(MAX_PER) + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_q;
    logic          at_end;

    assign last_q = CW'(step_period(mode, BASE_PERIOD) - 1);
    assign at_end = (cnt_q >= last_q);
    assign tick   = stb && busy && !clr && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || !busy) begin
            cnt_q <= '0;
        end else if (stb) begin
            cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        end
    end

    a_r9_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0)
        else $error("step count not cleared");

    a_r10_count_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!stb && !clr && busy) |=> cnt_q == $past(cnt_q))
        else $error("step count moved without strobe");

    a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(MAX_PER))
        else $error("step count out of range");
endmodule

// File: rtl/vr_chan_ramp.sv
module vr_chan_ramp
    import vr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [LVL_W-1:0] goal,
    output logic [LVL_W-1:0] level,
    output logic             busy
);
    ramp_state_t      state_q, state_n;
    logic [LVL_W-1:0] level_q, level_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SETTLED;
            level_q <= '1;
        end else begin
            state_q <= state_n;
            level_q <= level_n;
        end
    end

    // outputs: the level step chosen by the present direction
    always_comb begin
        level_n = level_q;
        unique case (state_q)
            ST_RISING:  if (tick && level_q < goal) level_n = level_q + 1'b1;
            ST_FALLING: if (tick && level_q > goal) level_n = level_q - 1'b1;
            default:    level_n = level_q;
        endcase
    end

    // next direction against the level that will be applied
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_SETTLED: begin
                if (goal > level_n)      state_n = ST_RISING;
                else if (goal < level_n) state_n = ST_FALLING;
            end
            ST_RISING: begin
                if (goal < level_n)       state_n = ST_FALLING;
                else if (goal == level_n) state_n = ST_SETTLED;
            end
            ST_FALLING: begin
                if (goal > level_n)       state_n = ST_RISING;
                else if (goal == level_n) state_n = ST_SETTLED;
            end
            default: state_n = ST_SETTLED;
        endcase
    end

    assign level = level_q;
    assign busy  = (state_q != ST_SETTLED);

    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        level_q != $past(level_q) |->
            (level_q == $past(level_q) + 1'b1) || (level_q == $past(level_q) - 1'b1))
        else $error("level jumped");

    a_r2_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        level_q != $past(level_q) |-> $past(tick))
        else $error("level moved without tick");

    a_r5_mute_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
        $past(goal) == '0 |-> level_q <= $past(level_q))
        else $error("level rose toward zero goal");

    a_r7_toward_goal: assert property (@(posedge clk) disable iff (!rst_n)
        level_q > $past(level_q) |-> $past(level_q) < $past(goal))
        else $error("level rose away from goal");
endmodule

// File: rtl/vr_scale.sv
module vr_scale
    import vr_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    stb,
    input  logic signed [SMP_W-1:0] sample,
    input  logic [LVL_W-1:0]        level,
    output logic signed [SMP_W-1:0] out
);
    localparam int PW = SMP_W + LVL_W + 1;
    localparam int LVL_MAX = (1 << LVL_W) - 1;

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] quot;

    assign prod = PW'(sample) * $signed({1'b0, level});
    assign quot = prod / PW'(LVL_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   out <= '0;
        else if (stb) out <= quot[SMP_W-1:0];
    end

    function automatic logic [SMP_W:0] mag(input logic signed [SMP_W-1:0] v);
        return v[SMP_W-1] ? (SMP_W+1)'(-$signed({v[SMP_W-1], v})) : {1'b0, v};
    endfunction

    a_r8_fits_width: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> (quot[PW-1:SMP_W-1] == '0) || (quot[PW-1:SMP_W-1] == '1))
        else $error("scaled value overflows");

    a_r8_no_gain: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stb) |-> mag(out) <= mag($past(sample)))
        else $error("output exceeds input magnitude");
endmodule

// File: rtl/vol_ramp_attenuator.sv
module vol_ramp_attenuator
    import vr_pkg::*;
#(
    parameter int unsigned BASE_PERIOD = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    timing_clr,
    input  logic                    frame_stb,
    input  logic [1:0]              speed_mode,
    input  logic                    soft_mute,
    input  logic [LVL_W-1:0]        target_l,
    input  logic [LVL_W-1:0]        target_r,
    input  logic signed [SMP_W-1:0] sample_l,
    input  logic signed [SMP_W-1:0] sample_r,
    output logic signed [SMP_W-1:0] out_l,
    output logic signed [SMP_W-1:0] out_r,
    output logic                    out_valid,
    output logic [LVL_W-1:0]        level_l,
    output logic [LVL_W-1:0]        level_r
);
    logic [LVL_W-1:0]        tgt   [NCH];
    logic signed [SMP_W-1:0] smp   [NCH];
    logic signed [SMP_W-1:0] res   [NCH];
    logic [LVL_W-1:0]        lvl   [NCH];
    logic [NCH-1:0]          busy_v;
    logic                    tick;

    assign tgt[0] = target_l;
    assign tgt[1] = target_r;
    assign smp[0] = sample_l;
    assign smp[1] = sample_r;

    vr_step_timer #(.BASE_PERIOD(BASE_PERIOD)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (timing_clr),
        .stb   (frame_stb),
        .busy  (|busy_v),
        .mode  (speed_mode),
        .tick  (tick)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic [LVL_W-1:0] goal;
        assign goal = soft_mute ? '0 : tgt[ch];

        vr_chan_ramp i_ramp (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .goal  (goal),
            .level (lvl[ch]),
            .busy  (busy_v[ch])
        );

        vr_scale i_scale (
            .clk    (clk),
            .rst_n  (rst_n),
            .stb    (frame_stb),
            .sample (smp[ch]),
            .level  (lvl[ch]),
            .out    (res[ch])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= frame_stb;
    end

    assign out_l   = res[0];
    assign out_r   = res[1];
    assign level_l = lvl[0];
    assign level_r = lvl[1];

    a_r8_valid_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(frame_stb))
        else $error("valid without strobe");

    a_r1_channels_hold_when_settled: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(|busy_v) |-> (level_l == $past(level_l)) && (level_r == $past(level_r)))
        else $error("settled level moved");
endmodule

// File: tb/test_vol_ramp_attenuator.sv
module test_vol_ramp_attenuator;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               timing_clr = 1'b0;
    logic               frame_stb = 1'b0;
    logic [1:0]         speed_mode = 2'b00;
    logic               soft_mute = 1'b0;
    logic [7:0]         target_l = 8'hFF;
    logic [7:0]         target_r = 8'hFF;
    logic signed [23:0] sample_l = '0;
    logic signed [23:0] sample_r = '0;
    logic signed [23:0] out_l, out_r;
    logic               out_valid;
    logic [7:0]         level_l, level_r;

    int checks = 0;
    int fails  = 0;
    int m_lvl [2];
    int m_cnt;

    always #5 clk = ~clk;

    vol_ramp_attenuator i_vol_ramp_attenuator (
        .clk(clk), .rst_n(rst_n), .timing_clr(timing_clr), .frame_stb(frame_stb),
        .speed_mode(speed_mode), .soft_mute(soft_mute), .target_l(target_l),
        .target_r(target_r), .sample_l(sample_l), .sample_r(sample_r),
        .out_l(out_l), .out_r(out_r), .out_valid(out_valid),
        .level_l(level_l), .level_r(level_r)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int period_of(input logic [1:0] m);
        return (m == 2'b00) ? 4 : (m == 2'b01) ? 8 : 16;
    endfunction

    function automatic int goal_of(input int ch);
        if (soft_mute) return 0;
        return (ch == 0) ? int'(target_l) : int'(target_r);
    endfunction

    function automatic longint exp_scale(input logic signed [23:0] s, input int lvl);
        longint p;
        p = longint'(s) * lvl;
        return p / 255;
    endfunction

    function automatic bit model_busy();
        return (m_lvl[0] != goal_of(0)) || (m_lvl[1] != goal_of(1));
    endfunction

    task automatic model_strobe();
        if (!model_busy()) m_cnt = 0;
        else if (m_cnt >= period_of(speed_mode) - 1) begin
            m_cnt = 0;
            for (int ch = 0; ch < 2; ch++) begin
                if (m_lvl[ch] < goal_of(ch)) m_lvl[ch]++;
                else if (m_lvl[ch] > goal_of(ch)) m_lvl[ch]--;
            end
        end else m_cnt++;
    endtask

    // apply new configuration between frames
    task automatic set_cfg(input logic [1:0] m, input logic mu, input logic [7:0] tl, input logic [7:0] tr);
        @(negedge clk);
        speed_mode = m; soft_mute = mu; target_l = tl; target_r = tr;
        if (!model_busy()) m_cnt = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic frame(input logic signed [23:0] sl, input logic signed [23:0] sr);
        longint el, er;
        @(negedge clk);
        chk("R2 level_l", level_l, m_lvl[0]);
        chk("R2 level_r", level_r, m_lvl[1]);
        sample_l = sl; sample_r = sr;
        el = exp_scale(sl, m_lvl[0]);
        er = exp_scale(sr, m_lvl[1]);
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
        chk("R8 out_valid", out_valid, 1);
        chk("R8 out_l", longint'(out_l), el);
        chk("R8 out_r", longint'(out_r), er);
        model_strobe();
        @(negedge clk);
        chk("R8 valid low", out_valid, 0);
    endtask

    function automatic logic signed [23:0] rnd_smp();
        return 24'($urandom);
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        int n;
        int low;
        void'($urandom(32'd20240611));
        m_lvl[0] = 255; m_lvl[1] = 255; m_cnt = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 level_l", level_l, 255);
        chk("R1 level_r", level_r, 255);
        chk("R1 out_l", longint'(out_l), 0);
        chk("R1 valid", out_valid, 0);

        // R8 full level passes samples, extremes included
        frame(24'sh7FFFFF, -24'sh800000);
        for (int i = 0; i < 10; i++) frame(rnd_smp(), rnd_smp());

        // R3 normal speed: left down to 0x80, right stays (independent, R1)
        set_cfg(2'b00, 1'b0, 8'h80, 8'hFF);
        for (int i = 0; i < 3; i++) frame(rnd_smp(), rnd_smp());
        chk("R3 no step before 4th strobe", level_l, 255);
        frame(rnd_smp(), rnd_smp());
        @(negedge clk);
        chk("R3 first step on 4th strobe", level_l, 254);
        chk("R1 right independent", level_r, 255);
        for (int i = 0; i < 40; i++) frame(rnd_smp(), rnd_smp());

        // R7 target reversed mid-ramp: heads back up
        set_cfg(2'b00, 1'b0, 8'hF8, 8'hFF);
        for (int i = 0; i < 30; i++) frame(rnd_smp(), rnd_smp());
        chk("R7 reversal up", level_l, m_lvl[0]);
        chk("R7 climbed", int'(level_l) > 245, 1);

        // R5/R6 soft mute released mid-ramp reverses
        set_cfg(2'b00, 1'b0, 8'hFF, 8'hFF);
        for (int i = 0; i < 40; i++) frame(rnd_smp(), rnd_smp());
        set_cfg(2'b00, 1'b1, 8'hFF, 8'hFF);
        for (int i = 0; i < 40; i++) frame(rnd_smp(), rnd_smp());
        low = level_r;
        chk("R5 mute ramps down", low, 245);
        set_cfg(2'b00, 1'b0, 8'hFF, 8'hFF);
        n = 0;
        while (level_r != 8'hFF && n < 200) begin frame(rnd_smp(), rnd_smp()); n++; end
        chk("R6 reversal back to target frames", n, 40);

        // R9 timing clear mid-count keeps level, restarts count (double speed)
        set_cfg(2'b01, 1'b0, 8'd200, 8'hFF);
        for (int i = 0; i < 5; i++) frame(rnd_smp(), rnd_smp());
        @(negedge clk);
        timing_clr = 1'b1;
        @(negedge clk);
        timing_clr = 1'b0;
        m_cnt = 0;
        chk("R9 level kept", level_l, 255);
        for (int i = 0; i < 7; i++) frame(rnd_smp(), rnd_smp());
        chk("R9 no step after 7", level_l, 255);
        frame(rnd_smp(), rnd_smp());
        @(negedge clk);
        chk("R9 R3 step on 8th after clear", level_l, 254);

        // R10 idle clock cycles without strobe do not advance
        repeat (50) @(negedge clk);
        chk("R10 no advance without strobe", level_l, 254);

        // R4 full mute ramp in quad speed takes 4080 strobes
        set_cfg(2'b10, 1'b0, 8'hFF, 8'hFF);
        while (level_l != 8'hFF) frame(rnd_smp(), rnd_smp());
        frame(rnd_smp(), rnd_smp());
        set_cfg(2'b10, 1'b1, 8'hFF, 8'hFF);
        n = 0;
        while (level_l != 8'h00 && n < 5000) begin frame(rnd_smp(), rnd_smp()); n++; end
        chk("R4 quad full ramp frames", n, 4080);
        frame(24'sh7FFFFF, -24'sh800000);
        chk("R8 muted output", longint'(out_l), 0);

        // R3 mode 11 behaves as quad; random targets and samples
        set_cfg(2'b11, 1'b0, 8'd3, 8'd1);
        for (int i = 0; i < 40; i++) frame(rnd_smp(), rnd_smp());
        chk("R3 mode11 period 16", level_l, 2);
        for (int k = 0; k < 6; k++) begin
            set_cfg(2'(k % 3), 1'b0, 8'($urandom), 8'($urandom));
            for (int i = 0; i < 60; i++) frame(rnd_smp(), rnd_smp());
        end
        frame(-24'sh000001, 24'sh000001);
        chk("R8 truncation small", longint'(out_l), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule